// File: doc/BRIEF.md
# Interrupt Controller Register Bank

This block is the software-visible state store of a nested vectored interrupt controller. For a configurable number of external interrupts it keeps an enable bit, a pending bit and a priority field. It also exposes the active bits that the exception logic drives in from outside. Each external interrupt has a target-non-secure bit, supplied as an input. The priority arbiter reads the enable, pending and priority state from flat output vectors.

Software reaches the block through a simple request/response register bus. Every request carries a byte offset, a size of 1, 2 or 4 bytes and a security attribute. The offset is turned into the first affected interrupt, using one of two packings:
- The enable, pending and active ranges hold one bit per interrupt.
- The priority range holds one byte per interrupt.

Each access then touches only those interrupts that exist and that its security state permits.

External interrupt k is exception number k+16. Bit and byte positions below are given by external index.

Top module: `irq_regbank`

## Requirements
- R1: A write to the set-enable range 0x100–0x13F sets each enable bit whose data bit is 1. A write to the clear-enable range 0x180–0x1BF clears each enable bit whose data bit is 1. Data bits of 0 leave state unchanged. Reads of either range return the enable bits, and `irq_enable_o` shows them.
- R2: The set-pending range 0x200–0x23F and the clear-pending range 0x280–0x2BF behave like the enable ranges, applied to the pending bits. A 1 on `irq_pend_i` sets that pending bit, and it stays set even when a clear-pending write names it in the same cycle.
- R3: The range 0x300–0x33F reads `irq_active_i` as it was in the cycle the request was accepted. Writes there are accepted and change nothing.
- R4: In the bit ranges, data bit j of an access at offset o maps to external interrupt 8*(o − range base) + j. `req_size_i` selects the access width: 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. An access of N bytes covers 8*N interrupts. Write data and read data are right-justified: bit 0 is the first affected interrupt.
- R5: The range 0x400–0x5EF holds one byte per interrupt. Byte k of an access at offset o maps to interrupt (o − 0x400) + k, and an access of N bytes covers N interrupts. Only the upper PRIO_BITS bits of each byte are stored. The lower bits read as zero.
- R6: Interrupt indices at or above NUM_IRQ read as zero in every range, and writes to them change nothing.
- R7: When `req_secure_i` is 0, an access sees or changes an interrupt only if that interrupt's `irq_ns_i` bit is 1. For other interrupts the bit or byte reads as zero and writes are ignored. Secure accesses see all interrupts.
- R8: An offset outside all of the ranges above reads as zero, and a write to it changes no state.
- R9: `req_ready_o` is always 1. `rsp_valid_o` is 1 in the cycle after each accepted request, with the read data in `rsp_rdata_o`. A write takes effect at the accepting edge, so the next request sees it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready (always 1) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_secure_i | input | 1 | Security attribute of the access |
| req_size_i | input | 2 | Access size code |
| req_addr_i | input | 12 | Byte offset |
| req_wdata_i | input | 32 | Right-justified write data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_rdata_o | output | 32 | Right-justified read data |
| irq_ns_i | input | NUM_IRQ | Target-non-secure bit per interrupt |
| irq_pend_i | input | NUM_IRQ | Hardware pending set |
| irq_active_i | input | NUM_IRQ | Active state from exception logic |
| irq_enable_o | output | NUM_IRQ | Enable bits |
| irq_pending_o | output | NUM_IRQ | Pending bits |
| irq_prio_o | output | NUM_IRQ*PRIO_BITS | Stored priority fields, interrupt 0 in the low bits |

## Verification
The bit ranges are tested with several access shapes:
- Accesses at a non-zero byte offset, including a one-byte access at 0x101. These separate the correct ×8 interrupt scaling from an unscaled offset.
- A priority access at an unaligned offset. This exposes a spurious ×8 in the byte packing.

A 4-byte write that runs past NUM_IRQ tests the bounds limit. Non-secure reads and writes over a mixed pattern of target bits show whether the gating works per interrupt. A hardware pending pulse that coincides with a clear-pending write decides which of the two wins. Writes to the active range and to offsets just past the decoded ranges are followed by read-back, to show that they change nothing.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  typedef enum logic [2:0] {
    RG_NONE,
    RG_SETEN,
    RG_CLREN,
    RG_SETPD,
    RG_CLRPD,
    RG_ACT,
    RG_PRIO
  } region_e;

  localparam int IDX_W = 10;  // covers bit-range base up to 504
endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
  import irq_bank_pkg::*;
(
  input  logic [11:0]      addr_i,
  input  logic [1:0]       size_i,
  output region_e          region_o,
  output logic [IDX_W-1:0] base_o,
  output logic [2:0]       nbytes_o
);
  always_comb begin
    unique case (size_i)
      2'd0:    nbytes_o = 3'd1;
      2'd1:    nbytes_o = 3'd2;
      default: nbytes_o = 3'd4;
    endcase
  end

  always_comb begin
    base_o = {1'b0, addr_i[5:0], 3'b000};
    unique case (addr_i[11:6])
      6'h04:   region_o = RG_SETEN;
      6'h06:   region_o = RG_CLREN;
      6'h08:   region_o = RG_SETPD;
      6'h0A:   region_o = RG_CLRPD;
      6'h0C:   region_o = RG_ACT;
      default: begin
        if (addr_i[11:9] == 3'b010 && addr_i[8:0] <= 9'h1EF) begin
          region_o = RG_PRIO;
          base_o   = {1'b0, addr_i[8:0]};  // byte packing: no scaling
        end else begin
          region_o = RG_NONE;
        end
      end
    endcase
  end
endmodule

// File: rtl/irq_bit_read.sv
module irq_bit_read
  import irq_bank_pkg::*;
#(
  parameter int N = 64
) (
  input  logic [N-1:0]     state_i,
  input  logic [N-1:0]     ns_i,
  input  logic             secure_i,
  input  logic [IDX_W-1:0] base_i,
  input  logic [2:0]       nbytes_i,
  output logic [31:0]      rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N; i++) begin
      int off;
      off = i - int'(base_i);
      if (off >= 0 && off < 8 * int'(nbytes_i) && (secure_i || ns_i[i]))
        rdata_o[off[4:0]] = state_i[i];
    end
  end
endmodule

// File: rtl/irq_bitfield.sv
module irq_bitfield
  import irq_bank_pkg::*;
#(
  parameter int N = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_en_i,
  input  logic             clr_en_i,
  input  logic             secure_i,
  input  logic [IDX_W-1:0] base_i,
  input  logic [2:0]       nbytes_i,
  input  logic [31:0]      wdata_i,
  input  logic [N-1:0]     ns_i,
  input  logic [N-1:0]     hw_set_i,
  output logic [N-1:0]     state_o,
  output logic [31:0]      rdata_o
);
  logic [N-1:0] hit_m, state_q;

  always_comb begin
    hit_m = '0;
    for (int i = 0; i < N; i++) begin
      int off;
      off = i - int'(base_i);
      if (off >= 0 && off < 8 * int'(nbytes_i) && (secure_i || ns_i[i]))
        hit_m[i] = wdata_i[off[4:0]];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic set_b, clr_b;
    assign set_b = (set_en_i & hit_m[g]) | hw_set_i[g];
    assign clr_b = clr_en_i & hit_m[g] & ~hw_set_i[g];  // hardware set wins
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    state_q[g] <= 1'b0;
      else if (set_b) state_q[g] <= 1'b1;
      else if (clr_b) state_q[g] <= 1'b0;
    end
  end

  assign state_o = state_q;

  irq_bit_read #(.N(N)) i_rd (
    .state_i (state_q),
    .ns_i    (ns_i),
    .secure_i(secure_i),
    .base_i  (base_i),
    .nbytes_i(nbytes_i),
    .rdata_o (rdata_o)
  );

  assert_ns_write_blocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_en_i || clr_en_i) && !secure_i)
      |=> (((state_q ^ $past(state_q)) & ~$past(ns_i) & ~$past(hw_set_i)) == '0));

  assert_hw_set_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_set_i != '0) |=> ((state_q & $past(hw_set_i)) == $past(hw_set_i)));
endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank
  import irq_bank_pkg::*;
#(
  parameter int N  = 64,
  parameter int PB = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             secure_i,
  input  logic [IDX_W-1:0] base_i,
  input  logic [2:0]       nbytes_i,
  input  logic [31:0]      wdata_i,
  input  logic [N-1:0]     ns_i,
  output logic [N*PB-1:0]  prio_o,
  output logic [31:0]      rdata_o
);
  logic [PB-1:0] prio_q [N];
  logic [N-1:0]  hit_m;
  logic [PB-1:0] new_m [N];

  always_comb begin
    hit_m   = '0;
    rdata_o = '0;
    for (int i = 0; i < N; i++) begin
      int off;
      off      = i - int'(base_i);
      new_m[i] = prio_q[i];
      if (off >= 0 && off < int'(nbytes_i) && (secure_i || ns_i[i])) begin
        hit_m[i]                   = wr_en_i;
        new_m[i]                   = wdata_i[off*8+7 -: PB];
        rdata_o[off*8+7 -: PB]     = prio_q[i];  // low bits stay zero
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_prio
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       prio_q[g] <= '0;
      else if (hit_m[g]) prio_q[g] <= new_m[g];
    end
    assign prio_o[g*PB +: PB] = prio_q[g];

    assert_prio_ns_blocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !secure_i && !ns_i[g]) |=> $stable(prio_q[g]));
  end
endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
  import irq_bank_pkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int PRIO_BITS = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_valid_i,
  output logic                         req_ready_o,
  input  logic                         req_write_i,
  input  logic                         req_secure_i,
  input  logic [1:0]                   req_size_i,
  input  logic [11:0]                  req_addr_i,
  input  logic [31:0]                  req_wdata_i,
  output logic                         rsp_valid_o,
  output logic [31:0]                  rsp_rdata_o,
  input  logic [NUM_IRQ-1:0]           irq_ns_i,
  input  logic [NUM_IRQ-1:0]           irq_pend_i,
  input  logic [NUM_IRQ-1:0]           irq_active_i,
  output logic [NUM_IRQ-1:0]           irq_enable_o,
  output logic [NUM_IRQ-1:0]           irq_pending_o,
  output logic [NUM_IRQ*PRIO_BITS-1:0] irq_prio_o
);
  region_e          region;
  logic [IDX_W-1:0] base;
  logic [2:0]       nbytes;
  logic             wr;
  logic [31:0]      en_rd, pd_rd, act_rd, pr_rd, rd_mux;

  assign req_ready_o = 1'b1;
  assign wr          = req_valid_i & req_write_i;

  irq_bank_decode i_dec (
    .addr_i  (req_addr_i),
    .size_i  (req_size_i),
    .region_o(region),
    .base_o  (base),
    .nbytes_o(nbytes)
  );

  irq_bitfield #(.N(NUM_IRQ)) i_enable (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_en_i(wr && region == RG_SETEN),
    .clr_en_i(wr && region == RG_CLREN),
    .secure_i(req_secure_i),
    .base_i  (base),
    .nbytes_i(nbytes),
    .wdata_i (req_wdata_i),
    .ns_i    (irq_ns_i),
    .hw_set_i({NUM_IRQ{1'b0}}),
    .state_o (irq_enable_o),
    .rdata_o (en_rd)
  );

  irq_bitfield #(.N(NUM_IRQ)) i_pending (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_en_i(wr && region == RG_SETPD),
    .clr_en_i(wr && region == RG_CLRPD),
    .secure_i(req_secure_i),
    .base_i  (base),
    .nbytes_i(nbytes),
    .wdata_i (req_wdata_i),
    .ns_i    (irq_ns_i),
    .hw_set_i(irq_pend_i),
    .state_o (irq_pending_o),
    .rdata_o (pd_rd)
  );

  irq_bit_read #(.N(NUM_IRQ)) i_active (
    .state_i (irq_active_i),
    .ns_i    (irq_ns_i),
    .secure_i(req_secure_i),
    .base_i  (base),
    .nbytes_i(nbytes),
    .rdata_o (act_rd)
  );

  irq_prio_bank #(.N(NUM_IRQ), .PB(PRIO_BITS)) i_prio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr && region == RG_PRIO),
    .secure_i(req_secure_i),
    .base_i  (base),
    .nbytes_i(nbytes),
    .wdata_i (req_wdata_i),
    .ns_i    (irq_ns_i),
    .prio_o  (irq_prio_o),
    .rdata_o (pr_rd)
  );

  always_comb begin
    unique case (region)
      RG_SETEN, RG_CLREN: rd_mux = en_rd;
      RG_SETPD, RG_CLRPD: rd_mux = pd_rd;
      RG_ACT:             rd_mux = act_rd;
      RG_PRIO:            rd_mux = pr_rd;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_rdata_o <= (req_valid_i && !req_write_i) ? rd_mux : '0;
    end
  end

  assert_unmapped_read_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && region == RG_NONE) |=> (rsp_rdata_o == '0));

  assert_enable_kept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && region != RG_SETEN && region != RG_CLREN)
      |=> $stable(irq_enable_o));

  assert_rsp_follows_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> rsp_valid_o);
endmodule

// File: tb/test_irq_regbank.sv
`timescale 1ns/1ps
module test_irq_regbank;
  localparam int N  = 40;
  localparam int PB = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b1;
  logic [1:0]    req_size = '0;
  logic [11:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [N-1:0]  ns_v = '0, hw_v = '0, act_v = '0;
  logic [N-1:0]  en_o, pd_o;
  logic [N*PB-1:0] pr_o;

  logic [N-1:0]  en_m = '0, pd_m = '0;
  logic [PB-1:0] pr_m [N];

  int vectors = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  irq_regbank #(.NUM_IRQ(N), .PRIO_BITS(PB)) i_irq_regbank (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_secure_i(req_secure), .req_size_i(req_size), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .irq_ns_i(ns_v), .irq_pend_i(hw_v), .irq_active_i(act_v),
    .irq_enable_o(en_o), .irq_pending_o(pd_o), .irq_prio_o(pr_o)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int nb(logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  // model per requirements R1-style ranges, bit packing R4, byte packing R5
  function automatic logic [31:0] model_read(logic [11:0] a, logic [1:0] sz, logic sec);
    logic [31:0] r = '0;
    int base;
    if (a >= 12'h400 && a <= 12'h5EF) begin
      base = int'(a) - 'h400;
      for (int k = 0; k < nb(sz); k++)
        if (base + k < N && (sec || ns_v[base+k])) r[k*8+7 -: PB] = pr_m[base+k];
    end else if (a[11:6] inside {6'h04, 6'h06, 6'h08, 6'h0A, 6'h0C}) begin
      base = 8 * int'(a[5:0]);
      for (int j = 0; j < 8 * nb(sz); j++)
        if (base + j < N && (sec || ns_v[base+j]))
          r[j] = (a[11:6] == 6'h04 || a[11:6] == 6'h06) ? en_m[base+j] :
                 (a[11:6] == 6'h0C) ? act_v[base+j] : pd_m[base+j];
    end
    return r;
  endfunction

  function automatic void model_write(logic [11:0] a, logic [1:0] sz, logic sec, logic [31:0] d);
    int base;
    if (a >= 12'h400 && a <= 12'h5EF) begin
      base = int'(a) - 'h400;
      for (int k = 0; k < nb(sz); k++)
        if (base + k < N && (sec || ns_v[base+k])) pr_m[base+k] = d[k*8+7 -: PB];
    end else if (a[11:6] inside {6'h04, 6'h06, 6'h08, 6'h0A}) begin
      base = 8 * int'(a[5:0]);
      for (int j = 0; j < 8 * nb(sz); j++)
        if (base + j < N && (sec || ns_v[base+j]) && d[j])
          case (a[11:6])
            6'h04: en_m[base+j] = 1'b1;
            6'h06: en_m[base+j] = 1'b0;
            6'h08: pd_m[base+j] = 1'b1;
            default: pd_m[base+j] = 1'b0;
          endcase
    end
    pd_m = pd_m | hw_v;
  endfunction

  task automatic bus(logic wr, logic [11:0] a, logic [1:0] sz, logic sec,
                     logic [31:0] d, logic [N-1:0] hw, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
    req_secure = sec; req_wdata = d; hw_v = hw;
    if (wr) begin
      model_write(a, sz, sec, d);
      exp_q.push_back(32'h0);
    end else begin
      exp_q.push_back(model_read(a, sz, sec));
    end
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0; hw_v = '0;
  endtask

  // monitor: pops scoreboard on each response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check("R9 unexpected response", 64'(rsp_rdata), 64'h0);
      else begin
        string t;
        logic [31:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 64'(rsp_rdata), 64'(e));
      end
    end
  end

  function automatic logic [N*PB-1:0] prio_flat();
    logic [N*PB-1:0] f;
    for (int i = 0; i < N; i++) f[i*PB +: PB] = pr_m[i];
    return f;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) pr_m[i] = '0;
    for (int i = 0; i < N; i++) ns_v[i] = (i % 3 == 0);
    act_v = 40'h5A_F0_0F_33_C1;
    repeat (3) @(negedge clk);
    check("R9 reset rsp_valid", 64'(rsp_valid), 64'h0);
    check("R1 reset enable", 64'(en_o), 64'h0);
    check("R2 reset pending", 64'(pd_o), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 ready", 64'(req_ready), 64'h1);

    bus(1, 12'h100, 2'd1, 1, 32'h0000_8001, '0, "R1 set-enable write");
    bus(0, 12'h100, 2'd1, 1, 0, '0, "R1 read set-enable");
    bus(0, 12'h180, 2'd1, 1, 0, '0, "R1 read clear-enable");
    bus(1, 12'h180, 2'd0, 1, 32'h01, '0, "R1 clear irq0");
    bus(0, 12'h100, 2'd1, 1, 0, '0, "R1 read after clear");
    bus(1, 12'h104, 2'd2, 1, 32'hFFFF_FFFF, '0, "R6 write past count");
    bus(0, 12'h104, 2'd2, 1, 0, '0, "R6 read past count");
    bus(1, 12'h101, 2'd0, 1, 32'h0F, '0, "R4 byte offset 1 set");
    bus(0, 12'h100, 2'd2, 1, 0, '0, "R4 scaled offset read");
    @(negedge clk);
    check("R1 enable_o", 64'(en_o), 64'(en_m));

    bus(1, 12'h200, 2'd1, 1, 32'h0000_00F0, '0, "R2 set-pending");
    bus(0, 12'h280, 2'd1, 1, 0, '0, "R2 read clear-pending");
    bus(1, 12'h280, 2'd0, 1, 32'h30, 40'h10, "R2 clear vs hw set");
    bus(0, 12'h200, 2'd0, 1, 0, '0, "R2 hw set wins");
    bus(1, 12'h202, 2'd0, 1, 32'h00, 40'h1_0000_0000, "R2 hw set irq32");
    @(negedge clk);
    check("R2 pending_o", 64'(pd_o), 64'(pd_m));

    bus(0, 12'h300, 2'd1, 1, 0, '0, "R3 active read");
    bus(0, 12'h304, 2'd0, 1, 0, '0, "R3 active upper byte");
    bus(1, 12'h300, 2'd2, 1, 32'hFFFF_FFFF, '0, "R3 active write ignored");
    bus(0, 12'h300, 2'd2, 1, 0, '0, "R3 active unchanged");

    bus(1, 12'h401, 2'd1, 1, 32'h0000_E0A0, '0, "R5 prio unaligned write");
    bus(0, 12'h400, 2'd2, 1, 0, '0, "R5 prio read");
    bus(1, 12'h403, 2'd0, 1, 32'hFF, '0, "R5 prio low bits");
    bus(0, 12'h403, 2'd0, 1, 0, '0, "R5 prio low bits zero");
    bus(1, 12'h426, 2'd2, 1, 32'h6040_2080, '0, "R6 prio past count");
    bus(0, 12'h424, 2'd2, 1, 0, '0, "R6 prio read past count");
    bus(1, 12'h4FF, 2'd0, 1, 32'hFF, '0, "R6 prio far index");

    bus(0, 12'h100, 2'd2, 0, 0, '0, "R7 ns enable read");
    bus(1, 12'h180, 2'd2, 0, 32'hFFFF_FFFF, '0, "R7 ns clear-enable");
    bus(0, 12'h100, 2'd2, 1, 0, '0, "R7 secure view after ns clear");
    bus(1, 12'h400, 2'd2, 0, 32'hFFFF_FFFF, '0, "R7 ns prio write");
    bus(0, 12'h400, 2'd2, 1, 0, '0, "R7 prio after ns write");
    bus(0, 12'h300, 2'd1, 0, 0, '0, "R7 ns active read");

    bus(0, 12'h0F0, 2'd2, 1, 0, '0, "R8 unmapped read");
    bus(1, 12'h140, 2'd2, 1, 32'hFFFF_FFFF, '0, "R8 unmapped write");
    bus(0, 12'h100, 2'd2, 1, 0, '0, "R8 enable unchanged");
    bus(1, 12'h5F0, 2'd2, 1, 32'hFFFF_FFFF, '0, "R8 past prio range write");
    @(negedge clk);
    check("R8 enable_o", 64'(en_o), 64'(en_m));
    check("R5 prio_o", 64'(pr_o), 64'(prio_flat()));
    repeat (2) @(negedge clk);
    check("R9 scoreboard drained", 64'(exp_q.size()), 64'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule